// File: doc/BRIEF.md
# Push-Button Debounce Controller

This block turns a bouncing mechanical push-button level into a clean level signal. The raw button first passes through a flop synchronizer. A six-state machine then looks at it only on sample ticks, which are slow compared to the system clock. A press is accepted when all of the following hold in order:

- a first high sample is seen;
- a fixed settling wait of several sample periods passes;
- three further consecutive samples are all high.

The clean output then stays high until a sample shows the button low. At that point the output drops and the machine returns to its idle state, ready for the next press.

The sample tick comes from one of two places, chosen by a parameter. It is either taken from the `sample_en_i` strobe, or produced inside the block by dividing the system clock. All logic is in the single system-clock domain. The reset is synchronous and active-high.

Top module: `btn_debounce`

## Requirements
- R1: While `rst` is high at a clock edge, and after it is released, `clean_o` is 0 and the machine is idle.
- R2: In idle, a low sample keeps the machine idle. A high sample starts the settling wait.
- R3: The settling wait lasts exactly `SETTLE_TICKS` sample ticks and ignores the button level. When the button is high on every tick, `clean_o` rises on the (`SETTLE_TICKS`+4)-th tick, counting the first high sample as tick 1.
- R4: During the three confirmation samples that follow the wait, any low sample returns the machine to idle. Nothing then rises until a complete new sequence has run.
- R5: `clean_o` is 1 only in the pressed state. It rises on the tick on which the third confirmation sample is high.
- R6: In the pressed state a high sample keeps `clean_o` at 1. A low sample clears `clean_o` on that same tick.
- R7: Between sample ticks the state and `clean_o` do not change, whatever the button does.
- R8: The raw button reaches the state machine through `SYNC_STAGES` flops (2 by default). A tick on either of the two clock edges that follow a change still uses the old level.
- R9: When `DIV_RATIO` is greater than 0, a tick occurs on every `DIV_RATIO`-th clock and `sample_en_i` is ignored. When `DIV_RATIO` is 0, `sample_en_i` is the tick.
- R10: The settling counter is reloaded every time the wait is entered, so each new press again needs the full wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw_i | input | 1 | Raw, unsynchronized button level (1 = pressed) |
| sample_en_i | input | 1 | Sample strobe; used only when DIV_RATIO is 0 |
| clean_o | output | 1 | Debounced button level, registered |

## Verification
The main instance is built with `SETTLE_TICKS` = 5 and `DIV_RATIO` = 0, so the bench sets every sample tick itself. This short wait means a full press takes only nine ticks. Random runs of high and low therefore often land aborts in the wait, in each confirmation state and in the pressed state.

A second instance uses `DIV_RATIO` = 3 with `SETTLE_TICKS` = 2 and has `sample_en_i` tied high. This puts the internal tick generator within reach, along with a check that the external strobe is ignored.

// File: rtl/btn_db_pkg.sv
package btn_db_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETTLE  = 3'd1,
    ST_CONF1   = 3'd2,
    ST_CONF2   = 3'd3,
    ST_CONF3   = 3'd4,
    ST_PRESSED = 3'd5
  } db_state_t;

endpackage

// File: rtl/btn_db_sync.sv
module btn_db_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/btn_db_tick.sv
module btn_db_tick #(
  parameter int DIV_RATIO = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_en_i,
  output logic tick_o
);

  generate
    if (DIV_RATIO == 0) begin : g_ext
      assign tick_o = ext_en_i;
    end else if (DIV_RATIO == 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(DIV_RATIO);
      localparam logic [DW-1:0] LAST = DW'(DIV_RATIO - 1);
      logic [DW-1:0] div_q;
      logic          tick_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          div_q  <= '0;
          tick_q <= 1'b0;
        end else begin
          tick_q <= (div_q == LAST - DW'(1));
          if (div_q == LAST) div_q <= '0;
          else               div_q <= div_q + DW'(1);
        end
      end

      assign tick_o = tick_q;

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);  // R9
    end
  endgenerate

endmodule

// File: rtl/btn_db_fsm.sv
module btn_db_fsm
  import btn_db_pkg::*;
#(
  parameter int SETTLE_TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic btn_i,
  output logic clean_o
);

  localparam int CW = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE_TICKS - 1);

  db_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          clean_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (btn_i) begin
          state_d = ST_SETTLE;
          cnt_d   = RELOAD;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == '0) state_d = ST_CONF1;
        else             cnt_d   = cnt_q - CW'(1);
      end
      ST_CONF1:   state_d = btn_i ? ST_CONF2   : ST_IDLE;
      ST_CONF2:   state_d = btn_i ? ST_CONF3   : ST_IDLE;
      ST_CONF3:   state_d = btn_i ? ST_PRESSED : ST_IDLE;
      ST_PRESSED: state_d = btn_i ? ST_PRESSED : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= RELOAD;
      clean_q <= 1'b0;
    end else if (tick_i) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      clean_q <= (state_d == ST_PRESSED);
    end
  end

  assign clean_o = clean_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($stable(state_q) && $stable(clean_q)));  // R7
  AST_IDLE_ARM: assert property (@(posedge clk) disable iff (rst)
    (tick_i && state_q == ST_IDLE && btn_i) |=> (state_q == ST_SETTLE && cnt_q == RELOAD));  // R10
  AST_CONF_ABORT: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !btn_i && (state_q == ST_CONF1 || state_q == ST_CONF2 || state_q == ST_CONF3))
      |=> state_q == ST_IDLE);  // R4
  AST_RISE_AFTER_CONF3: assert property (@(posedge clk) disable iff (rst)
    $rose(clean_q) |-> $past(state_q) == ST_CONF3);  // R5
  AST_RELEASE_DROP: assert property (@(posedge clk) disable iff (rst)
    (tick_i && state_q == ST_PRESSED && !btn_i) |=> (!clean_q && state_q == ST_IDLE));  // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= RELOAD);  // R3

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int SETTLE_TICKS = 50,
  parameter int DIV_RATIO    = 0,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw_i,
  input  logic sample_en_i,
  output logic clean_o
);

  logic btn_s;
  logic tick;

  btn_db_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (btn_raw_i),
    .q_o (btn_s)
  );

  btn_db_tick #(.DIV_RATIO(DIV_RATIO)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .ext_en_i (sample_en_i),
    .tick_o   (tick)
  );

  btn_db_fsm #(.SETTLE_TICKS(SETTLE_TICKS)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .btn_i   (btn_s),
    .clean_o (clean_o)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> !clean_o);  // R1

endmodule

// File: tb/btn_debounce_test.sv
module btn_debounce_test;

  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic en  = 1'b0;
  logic clean;
  logic btn2 = 1'b0;
  logic clean2;

  int n_checks = 0;
  int n_fail   = 0;

  // spec model state: 0 idle, 1 settle, 2..4 confirm, 5 pressed
  int m_st  = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  btn_debounce #(.SETTLE_TICKS(SETTLE), .DIV_RATIO(0)) uut (
    .clk(clk), .rst(rst), .btn_raw_i(btn), .sample_en_i(en), .clean_o(clean)
  );

  btn_debounce #(.SETTLE_TICKS(2), .DIV_RATIO(3)) uut_div (
    .clk(clk), .rst(rst), .btn_raw_i(btn2), .sample_en_i(1'b1), .clean_o(clean2)
  );

  function automatic int next_st(input int st, input int cnt, input logic b);
    case (st)
      0: return b ? 1 : 0;
      1: return (cnt == 0) ? 2 : 1;
      2, 3, 4: return b ? st + 1 : 0;
      default: return b ? 5 : 0;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: clean_o actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic b);
    int ns;
    ns = next_st(m_st, m_cnt, b);
    if (m_st == 0 && b) m_cnt = SETTLE - 1;
    else if (m_st == 1 && m_cnt != 0) m_cnt = m_cnt - 1;
    m_st = ns;
  endtask

  task automatic do_tick(input logic b, input string req);
    btn = b;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    model_step(b);
    check(req, clean, (m_st == 5));
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0; btn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_st = 0; m_cnt = SETTLE - 1;
    @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int len;
    logic lvl;
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 during reset", clean, 1'b0);
    check("R1 during reset div", clean2, 1'b0);
    do_reset();
    check("R1 after reset", clean, 1'b0);

    // R2 idle holds on low samples
    for (int i = 0; i < 4; i++) do_tick(1'b0, "R2 idle low");

    // R3 R5 clean press: rise on tick SETTLE+4
    for (int i = 0; i < SETTLE + 4; i++) do_tick(1'b1, "R3 R5 full press");
    check("R5 pressed high", clean, 1'b1);

    // R6 hold then release
    for (int i = 0; i < 3; i++) do_tick(1'b1, "R6 hold");
    do_tick(1'b0, "R6 release");
    check("R6 dropped", clean, 1'b0);

    // R3 settle ignores button level
    do_tick(1'b1, "R3 arm");
    for (int i = 0; i < SETTLE; i++) do_tick(i[0], "R3 settle ignores level");
    for (int i = 0; i < 3; i++) do_tick(1'b1, "R3 confirm");
    check("R3 rose after mixed settle", clean, 1'b1);
    do_tick(1'b0, "R6 release2");

    // R4 abort in each confirm state, R10 full wait again
    for (int k = 0; k < 3; k++) begin
      do_tick(1'b1, "R4 arm");
      for (int i = 0; i < SETTLE; i++) do_tick(1'b1, "R4 settle");
      for (int i = 0; i < k; i++) do_tick(1'b1, "R4 confirm");
      do_tick(1'b0, "R4 abort");
      check("R4 low after abort", clean, 1'b0);
    end
    for (int i = 0; i < SETTLE + 3; i++) do_tick(1'b1, "R10 not yet");
    check("R10 still low before full wait", clean, 1'b0);
    do_tick(1'b1, "R10 rise");
    check("R10 rise after full wait", clean, 1'b1);

    // R7 button glitches between ticks are ignored
    btn = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 no tick glitch", clean, 1'b1);
    do_tick(1'b1, "R7 still pressed");
    do_tick(1'b0, "R7 release");

    // R8 ticks on the two edges after a change see the old level
    btn = 1'b1;
    en  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    en  = 1'b0;
    check("R8 sync latency", clean, 1'b0);
    for (int i = 0; i < SETTLE + 4; i++) do_tick(1'b1, "R8 press after sync");
    check("R8 press timing", clean, 1'b1);
    do_tick(1'b0, "R8 release");

    // random runs
    for (int r = 0; r < 60; r++) begin
      len = 1 + int'($urandom_range(11));
      lvl = ($urandom_range(9) < 7);
      for (int i = 0; i < len; i++) do_tick(lvl, "R2 R4 R5 R6 random");
    end

    // R9 internal divider, external strobe tied high and ignored
    do_reset();
    btn2 = 1'b1;
    repeat (12) @(negedge clk);
    check("R9 strobe ignored", clean2, 1'b0);
    repeat (28) @(negedge clk);
    check("R9 divided press", clean2, 1'b1);
    btn2 = 1'b0;
    repeat (12) @(negedge clk);
    check("R9 divided release", clean2, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule